// File: doc/BRIEF.md
# Programmable RGB Display Timing Generator

This block produces the raster timing for a parallel RGB panel. It drives horizontal sync, vertical sync, data-enable and a pixel clock-enable strobe. Each line and each frame is built from four intervals whose lengths come from configuration pins. A source clock is divided down to the pixel rate by an 8-bit divider, and a pixel x/y position is output for the logic downstream that produces the pixel data.

Every interval and the divider are held as their length minus one. Each of the four outputs has its own inversion input. A new divider value is picked up only when a frame starts over at vertical sync, so that a frame never runs at a mix of rates. A sticky frame interrupt is raised when vertical sync begins and stays set until it is cleared. The configuration pins are plain levels, and no data flows through the block. The geometry pins should be changed only while `enable` is low. The divider pin may be changed at any time.

Top module: `rgb_timing_gen`

## Requirements
- R1: Each line is made of hsync pulse, back porch, active, front porch, in that order, and each lasts (its field + 1) pixels. hsync is active only during the pulse.
- R2: Each frame is made of vsync pulse, back porch, active, front porch lines, in that order, and each lasts (its field + 1) lines. vsync is active only during the pulse lines.
- R3: data-enable is active only when both the horizontal and the vertical position are in their active intervals. pix_x is the pixel index within the active part of the line (0 outside it). pix_y is the line index within the active lines (0 outside them).
- R4: The pixel strobe is active for one source-clock cycle out of every D, where D = cfg_div_m1 + 1. The raster advances by one pixel at the end of each strobe cycle. A field of 0 gives a strobe in every cycle.
- R5: A divider field of 255 is clamped to 254, so the largest divide is 255.
- R6: The divider in use is loaded from cfg_div_m1 while disabled and at each return to the first vsync pixel. A change made mid-frame does not alter the current frame.
- R7: Each output equals its active level XOR its own inversion input. An inactive output, including while disabled, therefore sits at the value of its inversion bit.
- R8: While enable is low, all four outputs are inactive and the raster is held at the first sync pixel (pix_x = pix_y = 0). On enable, output starts at that pixel.
- R9: When irq_en is high, irq sets at the transition from the last front-porch pixel into vsync. It does not set when enable first rises.
- R10: irq stays set until a cycle with irq_clr high clears it.
- R11: After reset, irq is low and all outputs are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the raster |
| cfg_hsync_m1 | input | 11 | Hsync pulse width minus one |
| cfg_hback_m1 | input | 11 | Horizontal back porch minus one |
| cfg_hact_m1 | input | 11 | Active pixels per line minus one |
| cfg_hfront_m1 | input | 11 | Horizontal front porch minus one |
| cfg_vsync_m1 | input | 11 | Vsync pulse lines minus one |
| cfg_vback_m1 | input | 11 | Vertical back porch lines minus one |
| cfg_vact_m1 | input | 11 | Active lines minus one |
| cfg_vfront_m1 | input | 11 | Vertical front porch lines minus one |
| cfg_div_m1 | input | 8 | Pixel clock divide minus one |
| inv_hsync | input | 1 | Invert hsync_o |
| inv_vsync | input | 1 | Invert vsync_o |
| inv_de | input | 1 | Invert de_o |
| inv_pclk_en | input | 1 | Invert pclk_en_o |
| irq_en | input | 1 | Allow the frame interrupt to set |
| irq_clr | input | 1 | Clear the frame interrupt |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pclk_en_o | output | 1 | Pixel clock-enable strobe |
| pix_x | output | 11 | Active pixel column |
| pix_y | output | 11 | Active line row |
| irq | output | 1 | Sticky frame interrupt |

## Verification
The bench predicts every pixel of whole frames and checks each strobe's sync, enable and position along with the cycle gap since the previous strobe. This catches an interval that is off by one, or phases in the wrong order, because the predicted stream would then slip. The divider is changed in the middle of a frame. A design that applies it at once shows the new gap before vsync, and one that never reloads it keeps the old gap after vsync. The bench also covers a divide of 1, where a bypass error drops strobes, and a field of 255, where a missing clamp gives a gap of 256. For the interrupt, it checks that enabling alone does not set irq, that irq sets exactly on the first vsync pixel, and that it holds until cleared. A design that treats enable as a frame start, or clears irq by itself, fails these checks.

// File: rtl/rgbt_pkg.sv
package rgbt_pkg;
  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_BACK   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_FRONT  = 2'd3
  } phase_e;

  function automatic phase_e phase_after(phase_e p);
    return phase_e'(p + 2'd1);
  endfunction
endpackage

// File: rtl/rgbt_clkdiv.sv
module rgbt_clkdiv #(
  parameter int DW        = 8,
  parameter int MAXDIV_M1 = 254
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic [DW-1:0] cfg_m1,
  output logic          tick
);
  localparam logic [DW-1:0] LIMIT = DW'(MAXDIV_M1);

  logic [DW-1:0] div_act;
  logic [DW-1:0] dcnt;
  logic [DW-1:0] cfg_eff;

  assign cfg_eff = (cfg_m1 > LIMIT) ? LIMIT : cfg_m1;
  assign tick    = run && (dcnt >= div_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt    <= '0;
      div_act <= '0;
    end else if (!run) begin
      dcnt    <= '0;
      div_act <= cfg_eff;
    end else begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (load) div_act <= cfg_eff;
    end
  end
endmodule

// File: rtl/rgbt_seq.sv
module rgbt_seq
  import rgbt_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               step,
  input  logic [3:0][CW-1:0] len_m1,
  output phase_e             phase,
  output logic [CW-1:0]      cnt,
  output logic               wrap
);
  logic          last;
  logic [CW-1:0] cur_len;

  assign cur_len = len_m1[phase];
  assign last    = (cnt >= cur_len);
  assign wrap    = step && last && (phase == PH_FRONT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (!run) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (step) begin
      if (last) begin
        cnt   <= '0;
        phase <= phase_after(phase);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen
  import rgbt_pkg::*;
#(
  parameter int H_W   = 11,
  parameter int V_W   = 11,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [H_W-1:0]   cfg_hsync_m1,
  input  logic [H_W-1:0]   cfg_hback_m1,
  input  logic [H_W-1:0]   cfg_hact_m1,
  input  logic [H_W-1:0]   cfg_hfront_m1,
  input  logic [V_W-1:0]   cfg_vsync_m1,
  input  logic [V_W-1:0]   cfg_vback_m1,
  input  logic [V_W-1:0]   cfg_vact_m1,
  input  logic [V_W-1:0]   cfg_vfront_m1,
  input  logic [DIV_W-1:0] cfg_div_m1,
  input  logic             inv_hsync,
  input  logic             inv_vsync,
  input  logic             inv_de,
  input  logic             inv_pclk_en,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             pclk_en_o,
  output logic [H_W-1:0]   pix_x,
  output logic [V_W-1:0]   pix_y,
  output logic             irq
);
  localparam int MAXDIV_M1 = (1 << DIV_W) - 2;

  logic               tick;
  logic               line_end;
  logic               frame_end;
  phase_e             hph;
  phase_e             vph;
  logic [H_W-1:0]     hcnt;
  logic [V_W-1:0]     vcnt;
  logic [3:0][H_W-1:0] h_len;
  logic [3:0][V_W-1:0] v_len;
  logic               irq_q;

  assign h_len = {cfg_hfront_m1, cfg_hact_m1, cfg_hback_m1, cfg_hsync_m1};
  assign v_len = {cfg_vfront_m1, cfg_vact_m1, cfg_vback_m1, cfg_vsync_m1};

  rgbt_clkdiv #(.DW(DIV_W), .MAXDIV_M1(MAXDIV_M1)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (enable),
    .load   (frame_end),
    .cfg_m1 (cfg_div_m1),
    .tick   (tick)
  );

  rgbt_seq #(.CW(H_W)) u_hseq (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (enable),
    .step   (tick),
    .len_m1 (h_len),
    .phase  (hph),
    .cnt    (hcnt),
    .wrap   (line_end)
  );

  rgbt_seq #(.CW(V_W)) u_vseq (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (enable),
    .step   (line_end),
    .len_m1 (v_len),
    .phase  (vph),
    .cnt    (vcnt),
    .wrap   (frame_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    irq_q <= 1'b0;
    else if (frame_end && irq_en)  irq_q <= 1'b1;
    else if (irq_clr)              irq_q <= 1'b0;
  end

  assign irq       = irq_q;
  assign hsync_o   = (enable && hph == PH_SYNC) ^ inv_hsync;
  assign vsync_o   = (enable && vph == PH_SYNC) ^ inv_vsync;
  assign de_o      = (enable && hph == PH_ACTIVE && vph == PH_ACTIVE) ^ inv_de;
  assign pclk_en_o = tick ^ inv_pclk_en;
  assign pix_x     = (hph == PH_ACTIVE) ? hcnt : '0;
  assign pix_y     = (vph == PH_ACTIVE) ? vcnt : '0;
endmodule

// File: rtl/rgbt_checker.sv
module rgbt_checker #(
  parameter int H_W = 11,
  parameter int V_W = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic           irq_clr,
  input logic           inv_hsync,
  input logic           inv_vsync,
  input logic           inv_de,
  input logic           hsync_o,
  input logic           vsync_o,
  input logic           de_o,
  input logic [H_W-1:0] pix_x,
  input logic [V_W-1:0] pix_y,
  input logic [H_W-1:0] cfg_hact_m1,
  input logic [V_W-1:0] cfg_vact_m1,
  input logic           irq
);
  logic de_a, hs_a, vs_a;
  assign de_a = de_o ^ inv_de;
  assign hs_a = hsync_o ^ inv_hsync;
  assign vs_a = vsync_o ^ inv_vsync;

  AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de_a |-> (!hs_a && !vs_a)); // R3
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    de_a |-> (pix_x <= cfg_hact_m1 && pix_y <= cfg_vact_m1)); // R3
  AST_IDLE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (pix_x == '0 && pix_y == '0)); // R8
  AST_IRQ_ON_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && enable) |-> (vs_a && pix_x == '0 && pix_y == '0)); // R9
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R10
endmodule

bind rgb_timing_gen rgbt_checker #(.H_W(H_W), .V_W(V_W)) u_rgbt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .irq_clr     (irq_clr),
  .inv_hsync   (inv_hsync),
  .inv_vsync   (inv_vsync),
  .inv_de      (inv_de),
  .hsync_o     (hsync_o),
  .vsync_o     (vsync_o),
  .de_o        (de_o),
  .pix_x       (pix_x),
  .pix_y       (pix_y),
  .cfg_hact_m1 (cfg_hact_m1),
  .cfg_vact_m1 (cfg_vact_m1),
  .irq         (irq)
);

// File: tb/rgb_timing_gen_bench.sv
module rgb_timing_gen_bench;
  localparam int HW = 11;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          en = 0, irq_en = 0, irq_clr = 0;
  logic          i_hs = 0, i_vs = 0, i_de = 0, i_ce = 0;
  logic [HW-1:0] c_hs = 0, c_hb = 0, c_ha = 0, c_hf = 0;
  logic [VW-1:0] c_vs = 0, c_vb = 0, c_va = 0, c_vf = 0;
  logic [7:0]    c_div = 0;
  logic          hsync_o, vsync_o, de_o, pclk_en_o, irq;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] pix_y;

  rgb_timing_gen u_rgb_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(en),
    .cfg_hsync_m1(c_hs), .cfg_hback_m1(c_hb), .cfg_hact_m1(c_ha), .cfg_hfront_m1(c_hf),
    .cfg_vsync_m1(c_vs), .cfg_vback_m1(c_vb), .cfg_vact_m1(c_va), .cfg_vfront_m1(c_vf),
    .cfg_div_m1(c_div), .inv_hsync(i_hs), .inv_vsync(i_vs), .inv_de(i_de),
    .inv_pclk_en(i_ce), .irq_en(irq_en), .irq_clr(irq_clr),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pclk_en_o(pclk_en_o),
    .pix_x(pix_x), .pix_y(pix_y), .irq(irq)
  );

  typedef struct {
    bit hs; bit vs; bit de; int x; int y; int gap;
  } pix_t;

  pix_t  exp_q[$];
  pix_t  mon_e;
  int    n_checks = 0;
  int    n_err = 0;
  int    hlen[4];
  int    vlen[4];
  string gap_tag = "R4";

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  // driver side: geometry in real lengths, fields get length-1
  task automatic set_geom(int hs, int hb, int ha, int hf, int vs, int vb, int va, int vf);
    hlen = '{hs, hb, ha, hf};
    vlen = '{vs, vb, va, vf};
    c_hs = HW'(hs - 1); c_hb = HW'(hb - 1); c_ha = HW'(ha - 1); c_hf = HW'(hf - 1);
    c_vs = VW'(vs - 1); c_vb = VW'(vb - 1); c_va = VW'(va - 1); c_vf = VW'(vf - 1);
  endtask

  task automatic push_frame(int d);
    for (int vp = 0; vp < 4; vp++)
      for (int vl = 0; vl < vlen[vp]; vl++)
        for (int hp = 0; hp < 4; hp++)
          for (int hc = 0; hc < hlen[hp]; hc++) begin
            pix_t p;
            p.hs  = (hp == 0);
            p.vs  = (vp == 0);
            p.de  = (hp == 2) && (vp == 2);
            p.x   = (hp == 2) ? hc : 0;
            p.y   = (vp == 2) ? vl : 0;
            p.gap = d;
            exp_q.push_back(p);
          end
  endtask

  task automatic start_run();
    @(posedge clk); #1 en = 1;
  endtask

  task automatic drain_and_stop();
    while (exp_q.size() > 0) @(posedge clk);
    #1 en = 0;
    @(negedge clk);
    chk("R8 x after disable", int'(pix_x), 0);
    chk("R8 strobe idle", int'(pclk_en_o ^ i_ce), 0);
  endtask

  // monitor: pops one expected pixel on each strobe
  int gap = 0;
  bit irq_prev = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      gap = 0;
      irq_prev = 0;
    end else begin
      if (en) begin
        gap++;
        if (pclk_en_o ^ i_ce) begin
          if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            chk("R1 hsync", int'(hsync_o ^ i_hs), int'(mon_e.hs));
            chk("R2 vsync", int'(vsync_o ^ i_vs), int'(mon_e.vs));
            chk("R3 de", int'(de_o ^ i_de), int'(mon_e.de));
            chk("R3 pix_x", int'(pix_x), mon_e.x);
            chk("R3 pix_y", int'(pix_y), mon_e.y);
            chk({"R4 gap ", gap_tag}, gap, mon_e.gap);
          end
          gap = 0;
        end
      end else begin
        gap = 0;
      end
      if (irq && !irq_prev && en) begin
        chk("R9 irq at vsync", int'(vsync_o ^ i_vs), 1);
        chk("R9 irq at first pixel", int'(pix_x) + int'(pix_y), 0);
      end
      irq_prev = irq;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    set_geom(2, 3, 4, 2, 1, 2, 3, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 hsync", int'(hsync_o), 0);
    chk("R11 vsync", int'(vsync_o), 0);
    chk("R11 de", int'(de_o), 0);
    chk("R11 strobe", int'(pclk_en_o), 0);
    chk("R11 irq", int'(irq), 0);
    chk("R11 pos", int'(pix_x) + int'(pix_y), 0);
    #1 rst_n = 1;

    // R7 idle levels follow inversion bits
    i_hs = 1; i_vs = 1; i_de = 1; i_ce = 1;
    @(negedge clk);
    chk("R7 hsync idle", int'(hsync_o), 1);
    chk("R7 vsync idle", int'(vsync_o), 1);
    chk("R7 de idle", int'(de_o), 1);
    chk("R7 strobe idle", int'(pclk_en_o), 1);
    i_hs = 0; i_vs = 0; i_de = 0; i_ce = 0;

    // bypass divide, no interrupt allowed
    c_div = 0; irq_en = 0;
    push_frame(1); push_frame(1);
    start_run();
    drain_and_stop();
    chk("R9 irq_en low", int'(irq), 0);

    // divide 3, all outputs inverted, interrupt on
    i_hs = 1; i_vs = 1; i_de = 1; i_ce = 1;
    c_div = 2; irq_en = 1;
    push_frame(3); push_frame(3);
    start_run();
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R9 no irq at enable", int'(irq), 0);
    drain_and_stop();
    chk("R10 irq held", int'(irq), 1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R10 irq still held", int'(irq), 1);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    chk("R10 irq cleared", int'(irq), 0);
    i_hs = 0; i_vs = 0; i_de = 0; i_ce = 0; irq_en = 0;

    // R6 divider change mid-frame waits for vsync
    gap_tag = "R6";
    c_div = 2;
    push_frame(3); push_frame(1);
    start_run();
    repeat (10) @(posedge clk);
    #1 c_div = 0;
    drain_and_stop();

    // R5 field 255 divides by 255
    gap_tag = "R5";
    set_geom(1, 1, 2, 1, 1, 1, 2, 1);
    c_div = 8'd255;
    push_frame(255);
    start_run();
    drain_and_stop();

    // R1 R2 another geometry with divide 2
    gap_tag = "R4";
    set_geom(3, 1, 5, 1, 2, 1, 2, 3);
    c_div = 1;
    push_frame(2);
    start_run();
    drain_and_stop();

    chk("R1 queue empty", exp_q.size(), 0);
    finish_run();
  end
endmodule